// File: doc/BRIEF.md
# Synchronized Manual Detect Pulse Generator

This block lets a host set symbol timing by hand instead of relying on the receiver's own power-based symbol detection. A software-writable trigger bit and an external trigger pin are ORed into one trigger level. The block treats that level as asynchronous and brings it into the baseband sampling clock domain through a synchronizer. When manual detection is enabled, each rising edge of the combined trigger gives exactly one detect pulse. On the same clock edge, the current in-phase and quadrature outputs of the matched filter are loaded into a holding register that feeds the demodulator.

When manual detection is disabled, the block passes the internal detect strobe through the same capture path, and manual trigger edges have no effect. When manual detection is enabled, the internal strobe is ignored. The captured I/Q pair stays at its value until the next detect pulse. The asynchronous reset input takes effect at once. Its release is synchronized to the sampling clock before the block leaves reset.

Top module: `manual_detect_gen`

## Requirements
- R1: While reset is active, det_pulse is 0 and dem_i and dem_q are 0, whatever the detect and trigger inputs do.
- R2: With man_en = 0, each clock edge at which int_det is 1 loads mf_i and mf_q into dem_i and dem_q, and det_pulse is 1 for the cycle that follows that edge.
- R3: With man_en = 1, int_det has no effect: det_pulse stays 0 and dem_i/dem_q keep their values.
- R4: With man_en = 1 and sw_trig held at 0, a rising edge on pin_trig loads the I/Q pair on the second rising clock edge after the trigger edge, and det_pulse is 1 for the one cycle after that edge.
- R5: With man_en = 1 and pin_trig held at 0, a rising edge on sw_trig behaves exactly as in R4.
- R6: While either trigger input is held at 1, a rising edge on the other one produces no pulse and no load.
- R7: With man_en = 0, rising trigger edges produce no pulse and no load.
- R8: A trigger held at 1 produces a single pulse, and dem_i/dem_q change only in a cycle where det_pulse is 1.
- R9: After a pulse, dem_i and dem_q equal the mf_i and mf_q values present at the loading clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| man_en | input | 1 | 1 selects manual detection, 0 passes the internal detect strobe |
| sw_trig | input | 1 | Software trigger bit, asynchronous to clk |
| pin_trig | input | 1 | External trigger pin, active high, asynchronous to clk |
| int_det | input | 1 | Internal detect strobe, synchronous to clk |
| mf_i | input | IQ_W | Matched filter in-phase output |
| mf_q | input | IQ_W | Matched filter quadrature output |
| det_pulse | output | 1 | One-cycle detect pulse |
| dem_i | output | IQ_W | In-phase value held for the demodulator |
| dem_q | output | IQ_W | Quadrature value held for the demodulator |

## Verification
The assertions check three things on every cycle:
- The held I/Q pair moves only together with a pulse, and then carries the matched filter values from the loading edge.
- With manual detection off, the internal strobe always turns into a pulse.
- In manual mode, two pulses never come back to back.

Other behaviours depend on trigger history and can only be shown by the bench's scenarios. These are the exact two-edge latency from a trigger edge, the OR masking while the other trigger is high, and the suppression of manual edges when manual mode is off. The bench covers them with a sweep over every before/after level combination of both triggers, in both modes, with and without an internal strobe.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_MANUAL   = 1'b1
  } det_src_e;

  function automatic det_src_e pick_src(input logic manual_on);
    return manual_on ? SRC_MANUAL : SRC_INTERNAL;
  endfunction

endpackage

// File: rtl/mdet_rst_sync.sv
module mdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_nxt;
  end

  assign rst_out_n = chain_q[STAGES-1];

endmodule

// File: rtl/mdet_sync.sv
module mdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl_last,
  output logic lvl_prev
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_nxt;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb stg_nxt[g] = async_in;
    end else begin : g_tail
      always_comb stg_nxt[g] = stg_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_nxt;
  end

  assign lvl_last = stg_q[TOP-1];
  assign lvl_prev = stg_q[TOP];

endmodule

// File: rtl/mdet_edge.sv
module mdet_edge (
  input  logic enable,
  input  logic lvl_new,
  input  logic lvl_old,
  output logic rise
);

  always_comb begin
    rise = enable & lvl_new & ~lvl_old;
  end

endmodule

// File: rtl/mdet_capture.sv
module mdet_capture #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic         pulse,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q
);

  logic [W-1:0] i_q, i_nxt;
  logic [W-1:0] q_q, q_nxt;
  logic         p_q, p_nxt;

  always_comb begin
    p_nxt = load;
    i_nxt = i_q;
    q_nxt = q_q;
    if (load) begin
      i_nxt = in_i;
      q_nxt = in_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= 1'b0;
      i_q <= '0;
      q_q <= '0;
    end else begin
      p_q <= p_nxt;
      i_q <= i_nxt;
      q_q <= q_nxt;
    end
  end

  assign pulse = p_q;
  assign out_i = i_q;
  assign out_q = q_q;

endmodule

// File: rtl/manual_detect_gen.sv
module manual_detect_gen
  import mdet_pkg::*;
#(
  parameter int IQ_W        = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            man_en,
  input  logic            sw_trig,
  input  logic            pin_trig,
  input  logic            int_det,
  input  logic [IQ_W-1:0] mf_i,
  input  logic [IQ_W-1:0] mf_q,
  output logic            det_pulse,
  output logic [IQ_W-1:0] dem_i,
  output logic [IQ_W-1:0] dem_q
);

  logic     rst_int_n;
  logic     trig_any;
  logic     lvl_last;
  logic     lvl_prev;
  logic     man_rise;
  logic     fire;
  det_src_e src_sel;

  mdet_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_out_n (rst_int_n)
  );

  always_comb trig_any = sw_trig | pin_trig;

  mdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (trig_any),
    .lvl_last (lvl_last),
    .lvl_prev (lvl_prev)
  );

  mdet_edge u_edge (
    .enable  (man_en),
    .lvl_new (lvl_last),
    .lvl_old (lvl_prev),
    .rise    (man_rise)
  );

  always_comb begin
    src_sel = pick_src(man_en);
    unique case (src_sel)
      SRC_MANUAL:   fire = man_rise;
      SRC_INTERNAL: fire = int_det;
      default:      fire = 1'b0;
    endcase
  end

  mdet_capture #(.W(IQ_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (fire),
    .in_i  (mf_i),
    .in_q  (mf_q),
    .pulse (det_pulse),
    .out_i (dem_i),
    .out_q (dem_q)
  );

endmodule

// File: rtl/mdet_chk.sv
module mdet_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         man_en,
  input logic         int_det,
  input logic [W-1:0] mf_i,
  input logic [W-1:0] mf_q,
  input logic         det_pulse,
  input logic [W-1:0] dem_i,
  input logic [W-1:0] dem_q
);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!det_pulse && dem_i == '0 && dem_q == '0);
    end
  end

  p_int_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(man_en) && $past(int_det)) |-> det_pulse);

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !det_pulse |-> ($stable(dem_i) && $stable(dem_q)));

  p_load_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> (dem_i == $past(mf_i) && dem_q == $past(mf_q)));

  p_single_manual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (det_pulse && $past(man_en) && man_en) |=> !det_pulse);

endmodule

bind manual_detect_gen mdet_chk #(.W(IQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .man_en    (man_en),
  .int_det   (int_det),
  .mf_i      (mf_i),
  .mf_q      (mf_q),
  .det_pulse (det_pulse),
  .dem_i     (dem_i),
  .dem_q     (dem_q)
);

// File: tb/tb_manual_detect_gen.sv
module tb_manual_detect_gen;

  localparam int W = 8;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         man_en;
  logic         sw_trig;
  logic         pin_trig;
  logic         int_det;
  logic [W-1:0] mf_i;
  logic [W-1:0] mf_q;
  logic         det_pulse;
  logic [W-1:0] dem_i;
  logic [W-1:0] dem_q;

  int vectors = 0;
  int miscompares = 0;
  int stamp = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  manual_detect_gen #(.IQ_W(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .man_en    (man_en),
    .sw_trig   (sw_trig),
    .pin_trig  (pin_trig),
    .int_det   (int_det),
    .mf_i      (mf_i),
    .mf_q      (mf_q),
    .det_pulse (det_pulse),
    .dem_i     (dem_i),
    .dem_q     (dem_q)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // Wait for a falling edge, then put new matched filter values on the inputs.
  task automatic tick();
    @(negedge clk);
    stamp++;
    mf_i = W'(stamp);
    mf_q = W'(stamp * 3 + 1);
  endtask

  task automatic chk(input string req, input logic exp_p,
                     input logic [W-1:0] exp_i, input logic [W-1:0] exp_q);
    vectors++;
    if (det_pulse !== exp_p || dem_i !== exp_i || dem_q !== exp_q) begin
      miscompares++;
      $display("FAIL %s: actual pulse=%0b i=%0d q=%0d expected pulse=%0b i=%0d q=%0d",
               req, det_pulse, dem_i, dem_q, exp_p, exp_i, exp_q);
    end
  endtask

  initial begin
    logic [W-1:0] hold_i, hold_q, v0_i, v0_q, v1_i, v1_q;
    logic init_or, fin_or, exp_int, exp_man;
    string req_t1, req_t2;

    rst_n = 1'b0; man_en = 1'b0; sw_trig = 1'b0; pin_trig = 1'b0;
    int_det = 1'b1; mf_i = '0; mf_q = '0;
    repeat (3) begin
      tick();
      chk("R1", 1'b0, '0, '0);
    end
    int_det = 1'b0;
    rst_n = 1'b1;
    repeat (5) tick();
    chk("R1", 1'b0, '0, '0);

    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 16; c++) begin
        for (int d = 0; d < 2; d++) begin
          tick();
          man_en = m[0]; sw_trig = c[0]; pin_trig = c[1]; int_det = 1'b0;
          repeat (4) tick();
          hold_i = dem_i; hold_q = dem_q;
          init_or = c[0] | c[1];
          fin_or  = c[2] | c[3];

          tick();
          v0_i = mf_i; v0_q = mf_q;
          sw_trig = c[2]; pin_trig = c[3]; int_det = d[0];

          tick();
          v1_i = mf_i; v1_q = mf_q;
          int_det = 1'b0;
          exp_int = (m == 0) && (d == 1);
          if (exp_int) begin hold_i = v0_i; hold_q = v0_q; end
          req_t1 = (m == 1) ? "R3" : (d == 1 ? "R2/R9" : "R7");
          chk(req_t1, exp_int, hold_i, hold_q);

          tick();
          exp_man = (m == 1) && !init_or && fin_or;
          if (exp_man) begin hold_i = v1_i; hold_q = v1_q; end
          if (m == 0)           req_t2 = "R7";
          else if (exp_man)     req_t2 = c[3] ? "R4/R9" : "R5/R9";
          else if (init_or)     req_t2 = "R6";
          else                  req_t2 = "R8";
          chk(req_t2, exp_man, hold_i, hold_q);

          tick();
          chk("R8", 1'b0, hold_i, hold_q);
          tick();
          chk("R8", 1'b0, hold_i, hold_q);
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule